// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block chooses the source of a protected output rail: the main supply or a backup battery. It works on digitized supply levels. Each clock cycle it samples three unsigned millivolt codes: the main supply, the battery, and the reset threshold. From these it drives a registered battery-path select, a battery-on indicator, a flag that tells the rest of the supervisor to ignore its user inputs, and a request to hold the system reset. The analog sensing, the power switches and the rail itself are outside the block.

The controller leaves reset in a start-up state. In that state the rail is never handed to the battery, whatever the battery reads. It arms only after the main supply has reached the threshold once. After that, backup mode needs two conditions together: the main supply is below the threshold, and the battery leads the main supply by at least a hysteresis offset. The block returns to the main supply when the main supply recovers to the threshold, or when it leads the battery by the same offset. The two offsets form a window that stops a slowly falling supply from toggling the source. All comparisons use one extra bit of width, so a code near full scale cannot wrap.

Top module: `supply_switchover`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `batt_sel`, `batt_on` and `inputs_ignored` are 0 and `hold_reset` is 1.
- R2: From reset the block stays in start-up (`batt_sel` 0, `hold_reset` 1) whatever `batt_mv` is, until a clock edge at which `main_mv >= thresh_mv`. After that edge it is in main mode, with `hold_reset` 0 and `batt_sel` 0.
- R3: In main mode, `batt_sel` rises at the first clock edge where `main_mv < thresh_mv` and `batt_mv >= main_mv + HYST_MV` (HYST_MV defaults to 20). A lead of HYST_MV-1 is not enough.
- R4: While `main_mv >= thresh_mv`, backup mode is never entered, whatever `batt_mv` is. This includes equality with the threshold.
- R5: In backup mode, `batt_sel` falls at the first clock edge where `main_mv >= batt_mv + HYST_MV` or `main_mv >= thresh_mv`.
- R6: Inside the hysteresis window (the main supply below the threshold, and each supply short of leading the other by HYST_MV), the current mode is kept.
- R7: `batt_on` equals `batt_sel` on every cycle.
- R8: While in backup mode, both `inputs_ignored` and `hold_reset` are 1. In main mode both are 0.
- R9: A battery code of 0 never allows entry into backup mode.
- R10: The sums used in the comparisons are W+1 bits wide, so codes near full scale do not wrap. With W=12: threshold 4095, main 4085, battery 4095 gives no entry. Main 4075 with battery 4095 enters. Main 4090 then keeps backup mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_mv | input | W | Main supply level, millivolts |
| batt_mv | input | W | Battery level, millivolts (0 = no battery) |
| thresh_mv | input | W | Reset threshold, millivolts |
| batt_sel | output | 1 | 1 = rail fed from battery |
| batt_on | output | 1 | Battery-on indicator |
| inputs_ignored | output | 1 | Supervisor user inputs to be ignored |
| hold_reset | output | 1 | Request to keep system reset asserted |

## Verification
Assertions check on every cycle that the indicator and the ignore flag follow the select, and that the battery path is never chosen in start-up, with a zero battery, or while the main supply is at or above the threshold. They also check that every rise of the select is backed by the entry comparison, and that a clear main-supply lead always forces an exit. Only the bench scenarios can show the exact boundary codes: the 19 versus 20 millivolt lead, the unchanged mode inside the window, and the full-scale codes where a narrow sum would wrap. They also show that start-up ends only on the first threshold crossing.

// File: rtl/swo_pkg.sv
package swo_pkg;

    typedef enum logic [1:0] {
        SW_START  = 2'd0,
        SW_MAIN   = 2'd1,
        SW_BACKUP = 2'd2
    } sw_mode_e;

    typedef struct packed {
        sw_mode_e mode;
        logic     sel;
        logic     hold;
    } sw_state_t;

endpackage

// File: rtl/swo_compare.sv
module swo_compare #(
    parameter int unsigned W       = 12,
    parameter int unsigned HYST_MV = 20
) (
    input  logic [W-1:0] main_mv,
    input  logic [W-1:0] batt_mv,
    input  logic [W-1:0] thresh_mv,
    output logic         below_th,
    output logic         batt_lead,
    output logic         main_lead
);
    localparam int unsigned EW = W + 1;
    localparam logic [EW-1:0] HYST_E = EW'(HYST_MV);

    logic [EW-1:0] main_e;
    logic [EW-1:0] batt_e;
    logic [EW-1:0] main_plus;
    logic [EW-1:0] batt_plus;
    logic          batt_absent;

    always_comb begin
        main_e      = {1'b0, main_mv};
        batt_e      = {1'b0, batt_mv};
        main_plus   = main_e + HYST_E;
        batt_plus   = batt_e + HYST_E;
        batt_absent = (batt_mv == '0);
        below_th    = (main_mv < thresh_mv);
        batt_lead   = !batt_absent && (batt_e >= main_plus);
        main_lead   = (main_e >= batt_plus);
    end

endmodule

// File: rtl/swo_fsm.sv
module swo_fsm
    import swo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_th,
    input  logic batt_lead,
    input  logic main_lead,
    output logic sel_q_o,
    output logic hold_q_o
);
    sw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            SW_START:  if (!below_th)             st_d.mode = SW_MAIN;
            SW_MAIN:   if (below_th && batt_lead) st_d.mode = SW_BACKUP;
            SW_BACKUP: if (!below_th || main_lead) st_d.mode = SW_MAIN;
            default:                              st_d.mode = SW_START;
        endcase
        st_d.sel  = (st_d.mode == SW_BACKUP);
        st_d.hold = (st_d.mode != SW_MAIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= SW_START;
            st_q.sel  <= 1'b0;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q_o  = st_q.sel;
    assign hold_q_o = st_q.hold;

    // R2: start-up never hands the rail straight to the battery
    a_r2_no_battery_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SW_START) |=> (st_q.mode != SW_BACKUP));

endmodule

// File: rtl/supply_switchover.sv
module supply_switchover #(
    parameter int unsigned W       = 12,
    parameter int unsigned HYST_MV = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] main_mv,
    input  logic [W-1:0] batt_mv,
    input  logic [W-1:0] thresh_mv,
    output logic         batt_sel,
    output logic         batt_on,
    output logic         inputs_ignored,
    output logic         hold_reset
);
    logic below_th;
    logic batt_lead;
    logic main_lead;
    logic sel_q;
    logic hold_q;

    swo_compare #(.W(W), .HYST_MV(HYST_MV)) u_cmp (
        .main_mv   (main_mv),
        .batt_mv   (batt_mv),
        .thresh_mv (thresh_mv),
        .below_th  (below_th),
        .batt_lead (batt_lead),
        .main_lead (main_lead)
    );

    swo_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_th  (below_th),
        .batt_lead (batt_lead),
        .main_lead (main_lead),
        .sel_q_o   (sel_q),
        .hold_q_o  (hold_q)
    );

    assign batt_sel       = sel_q;
    assign batt_on        = sel_q;
    assign inputs_ignored = sel_q;
    assign hold_reset     = hold_q;

    // R3: a rise of the select is backed by both entry conditions
    a_r3_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_sel) |-> $past(below_th && batt_lead));

    // R4: never enter while the main supply is at or above the threshold
    a_r4_no_entry_above: assert property (@(posedge clk) disable iff (!rst_n)
        (!batt_sel && main_mv >= thresh_mv) |=> !batt_sel);

    // R5: a clear main-supply lead forces an exit
    a_r5_exit_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_sel && ({1'b0, main_mv} >= {1'b0, batt_mv} + (W+1)'(HYST_MV))) |=> !batt_sel);

    // R7: indicator tracks the select
    a_r7_indicator: assert property (@(posedge clk) disable iff (!rst_n)
        batt_on == batt_sel);

    // R8: backup mode blocks user inputs and holds reset
    a_r8_backup_flags: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> (inputs_ignored && hold_reset));

    // R9: a zero battery never allows entry
    a_r9_zero_battery: assert property (@(posedge clk) disable iff (!rst_n)
        (!batt_sel && batt_mv == '0) |=> !batt_sel);

endmodule

// File: tb/supply_switchover_tb.sv
`timescale 1ns/1ps
module supply_switchover_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] main_mv = '0;
    logic [W-1:0] batt_mv = '0;
    logic [W-1:0] thresh_mv = 12'd3000;
    logic         batt_sel, batt_on, inputs_ignored, hold_reset;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bit    exp_sel_q[$];
    bit    exp_hold_q[$];
    string exp_tag_q[$];

    supply_switchover #(.W(W), .HYST_MV(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .main_mv(main_mv), .batt_mv(batt_mv),
        .thresh_mv(thresh_mv), .batt_sel(batt_sel), .batt_on(batt_on),
        .inputs_ignored(inputs_ignored), .hold_reset(hold_reset)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: apply codes, queue the result expected after the next edge
    task automatic drive(int vm, int vb, int vt, bit e_sel, bit e_hold, string tag);
        @(negedge clk);
        main_mv   = W'(vm);
        batt_mv   = W'(vb);
        thresh_mv = W'(vt);
        exp_sel_q.push_back(e_sel);
        exp_hold_q.push_back(e_hold);
        exp_tag_q.push_back(tag);
    endtask

    // monitor: sample shortly after each edge
    always @(posedge clk) begin
        #2;
        if (exp_sel_q.size() > 0) begin
            bit    es, eh;
            string tg;
            es = exp_sel_q.pop_front();
            eh = exp_hold_q.pop_front();
            tg = exp_tag_q.pop_front();
            check(tg, "batt_sel", int'(batt_sel), int'(es));
            check(tg, "hold_reset", int'(hold_reset), int'(eh));
            check("R7", "batt_on", int'(batt_on), int'(es));
            check("R8", "inputs_ignored", int'(inputs_ignored), int'(es));
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        batt_mv = 12'd3000;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs held at reset values
        check("R1", "batt_sel", int'(batt_sel), 0);
        check("R1", "batt_on", int'(batt_on), 0);
        check("R1", "inputs_ignored", int'(inputs_ignored), 0);
        check("R1", "hold_reset", int'(hold_reset), 1);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: start-up holds against a present battery
        drive(0,    3000, 3000, 0, 1, "R2");
        drive(2990, 3300, 3000, 0, 1, "R2");
        drive(3100, 3300, 3000, 0, 0, "R2");
        // R4: at or above threshold, no entry
        drive(3050, 3500, 3000, 0, 0, "R4");
        drive(3000, 4000, 3000, 0, 0, "R4");
        // R3: lead of 19 is too little
        drive(2900, 2919, 3000, 0, 0, "R3");
        // R9: zero battery blocks entry
        drive(2900, 0,    3000, 0, 0, "R9");
        // R3 / R8: lead of 20 enters
        drive(2900, 2920, 3000, 1, 1, "R3");
        // R6: inside window keeps backup
        drive(2910, 2920, 3000, 1, 1, "R6");
        drive(2939, 2920, 3000, 1, 1, "R6");
        // R5: main leads by 20 -> exit
        drive(2940, 2920, 3000, 0, 0, "R5");
        // R6: window keeps main
        drive(2930, 2920, 3000, 0, 0, "R6");
        drive(2000, 2900, 3000, 1, 1, "R8");
        drive(1000, 2900, 3000, 1, 1, "R6");
        // R5: exit by reaching threshold
        drive(3000, 3500, 3000, 0, 0, "R5");
        // R10: full-scale codes
        drive(4085, 4095, 4095, 0, 0, "R10");
        drive(4080, 4095, 4095, 0, 0, "R10");
        drive(4075, 4095, 4095, 1, 1, "R10");
        drive(4090, 4095, 4095, 1, 1, "R10");
        drive(3200, 4095, 3000, 0, 0, "R5");
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule